// File: doc/BRIEF.md
# Audio clock and data routing matrix

This block is a register-controlled crossbar for an audio subsystem with two clock domains. Domain 1 joins the first serial port of a two-port codec, an S/PDIF transmitter, oscillator 1 and PCM header 1. Domain 2 joins the codec's second port, an S/PDIF receiver, oscillator 2 and PCM header 2. For each domain the block picks the master clock and the bit/frame sub-clock source. It also decides which device is sub-clock master and whether the header sub-clock pins drive out or listen. Two serial data selects feed the codec data input and the transmitter data input.

Software programs the matrix through a small byte-addressed register file. The bus is synchronous: a write takes effect at the clock edge where it is sampled, and read data is registered one cycle after the read strobe. Either domain may copy the other's master clock or sub-clocks. When both domains point at each other, the block breaks the loop in favour of domain 1's local source. All clock and data paths are combinational muxes from the register state.

Top module: `audio_route_matrix`

## Requirements
- R1: Address 0x01 reads the parameter REV_ID. Writes to 0x01 change nothing.
- R2: After reset the registers read: 0x02 = 0x20, 0x03 = 0x11, 0x04 = 0x00, 0x05 = 0x00.
- R3: Only these bits are writable, and every other bit reads zero: 0x02 mask 0x33, 0x03 mask 0x33, 0x04 mask 0x03, 0x05 mask 0x30.
- R4: A read of an address other than 0x01..0x05 returns 0x00. A write to such an address changes no register.
- R5: The master clock 2 select is field 0x02[5:4]: 0 = oscillator 2, 1 = header 2 clock pin, 2 = receiver recovered clock, 3 = master clock 1. The header 2 clock pin enable is 0 only in code 1.
- R6: The master clock 1 select is field 0x02[1:0]: 0 = oscillator 1, 1 = header 1 clock pin, 2 = reserved (output low), 3 = master clock 2. The header 1 clock pin enable is 0 in codes 1 and 2.
- R7: When both master clock fields are 3, both master clocks carry oscillator 1.
- R8: The domain 2 sub-clock mode is field 0x03[5:4]: 0 = codec master, 1 = receiver master, 2 = header master (header 2 pins are inputs), 3 = copy of the domain 1 sub-clocks. The codec, receiver and header 2 sub-clock outputs all carry the selected domain bus. Each sub-clock vector has bit 1 = frame clock and bit 0 = bit clock.
- R9: The domain 1 sub-clock mode is field 0x03[1:0], with the same codes: codec, transmitter, header 1, or copy of domain 2.
- R10: When both sub-clock fields are 3, domain 1 behaves as codec master and domain 2 copies it.
- R11: In every mode, exactly one driver owns each domain's sub-clock bus. The drivers are the codec master flag, the device master flag, the header as input (pin enable 0), and the copy mode.
- R12: Codec data input field 0x04[1:0] and transmitter data input field 0x05[5:4] use these codes: 0 = receiver data, 1 = codec data out, 2 = header data, 3 = reserved (output low).
- R13: rdata_o changes only in the cycle after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register byte address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| osc1_i | input | 1 | Oscillator 1 |
| osc2_i | input | 1 | Oscillator 2 |
| hdr1_mclk_i | input | 1 | Header 1 master clock pin |
| hdr2_mclk_i | input | 1 | Header 2 master clock pin |
| rx_rmck_i | input | 1 | Receiver recovered master clock |
| mclk1_o | output | 1 | Domain 1 master clock |
| mclk2_o | output | 1 | Domain 2 master clock |
| hdr1_mclk_oe_o | output | 1 | Header 1 clock pin drive enable |
| hdr2_mclk_oe_o | output | 1 | Header 2 clock pin drive enable |
| codec_sub1_i | input | 2 | Codec port 1 sub-clocks when master |
| tx_sub_i | input | 2 | Transmitter sub-clocks when master |
| hdr1_sub_i | input | 2 | Header 1 sub-clock pins |
| codec_sub1_o | output | 2 | Sub-clocks to codec port 1 |
| tx_sub_o | output | 2 | Sub-clocks to transmitter |
| hdr1_sub_o | output | 2 | Sub-clocks to header 1 |
| codec_ms1_o | output | 1 | Codec port 1 is master |
| tx_ms_o | output | 1 | Transmitter is master |
| hdr1_sub_oe_o | output | 1 | Header 1 sub-clock pins drive |
| codec_sub2_i | input | 2 | Codec port 2 sub-clocks when master |
| rx_sub_i | input | 2 | Receiver sub-clocks when master |
| hdr2_sub_i | input | 2 | Header 2 sub-clock pins |
| codec_sub2_o | output | 2 | Sub-clocks to codec port 2 |
| rx_sub_o | output | 2 | Sub-clocks to receiver |
| hdr2_sub_o | output | 2 | Sub-clocks to header 2 |
| codec_ms2_o | output | 1 | Codec port 2 is master |
| rx_ms_o | output | 1 | Receiver is master |
| hdr2_sub_oe_o | output | 1 | Header 2 sub-clock pins drive |
| codec_sdout_i | input | 1 | Codec serial data out |
| rx_sdout_i | input | 1 | Receiver serial data out |
| hdr_sdata_i | input | 1 | Header serial data |
| codec_sdin_o | output | 1 | Codec serial data input |
| tx_sdin_o | output | 1 | Transmitter serial data input |

## Verification
The assertions assume the bus strobes and address are stable around each rising clock edge. They also assume the clock and data sources change only between edges, so the combinational routing outputs are settled when a property samples them. The stimulus drives every input on the falling edge and checks outputs just after that edge. It uses distinct bit patterns on each source so that a wrong mux leg shows up as a different value. Read and write strobes are single-cycle pulses with the address held for the full cycle.

// File: rtl/aud_route_pkg.sv
package aud_route_pkg;
  localparam int REG_W = 8;
  localparam int SUB_W = 2;
  localparam int NUM_DOM = 2;

  localparam int ADR_REV  = 1;
  localparam int ADR_MCLK = 2;
  localparam int ADR_SUB  = 3;
  localparam int ADR_CDIN = 4;
  localparam int ADR_TDIN = 5;

  localparam logic [REG_W-1:0] MSK_MCLK = 8'h33;
  localparam logic [REG_W-1:0] MSK_SUB  = 8'h33;
  localparam logic [REG_W-1:0] MSK_CDIN = 8'h03;
  localparam logic [REG_W-1:0] MSK_TDIN = 8'h30;

  localparam logic [REG_W-1:0] RST_MCLK = 8'h20;
  localparam logic [REG_W-1:0] RST_SUB  = 8'h11;
  localparam logic [REG_W-1:0] RST_CDIN = 8'h00;
  localparam logic [REG_W-1:0] RST_TDIN = 8'h00;

  typedef enum logic [1:0] {
    SUB_CODEC = 2'd0,
    SUB_DEV   = 2'd1,
    SUB_HDR   = 2'd2,
    SUB_COPY  = 2'd3
  } sub_mode_e;

  typedef enum logic [1:0] {
    DIN_RX   = 2'd0,
    DIN_LOOP = 2'd1,
    DIN_HDR  = 2'd2,
    DIN_RSV  = 2'd3
  } din_sel_e;
endpackage

// File: rtl/aud_route_regs.sv
module aud_route_regs
  import aud_route_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [REG_W-1:0] REV_ID = 8'h1A
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [1:0]       mclk1_sel_o,
  output logic [1:0]       mclk2_sel_o,
  output logic [1:0]       sub1_sel_o,
  output logic [1:0]       sub2_sel_o,
  output logic [1:0]       cdin_sel_o,
  output logic [1:0]       tdin_sel_o
);
  logic [REG_W-1:0] mclk_q, sub_q, cdin_q, tdin_q, rd_mux;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mclk_q <= RST_MCLK;
      sub_q  <= RST_SUB;
      cdin_q <= RST_CDIN;
      tdin_q <= RST_TDIN;
    end else if (wr_en_i) begin
      case (addr_i)
        ADDR_W'(ADR_MCLK): mclk_q <= wdata_i & MSK_MCLK;
        ADDR_W'(ADR_SUB):  sub_q  <= wdata_i & MSK_SUB;
        ADDR_W'(ADR_CDIN): cdin_q <= wdata_i & MSK_CDIN;
        ADDR_W'(ADR_TDIN): tdin_q <= wdata_i & MSK_TDIN;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_W'(ADR_REV):  rd_mux = REV_ID;
      ADDR_W'(ADR_MCLK): rd_mux = mclk_q;
      ADDR_W'(ADR_SUB):  rd_mux = sub_q;
      ADDR_W'(ADR_CDIN): rd_mux = cdin_q;
      ADDR_W'(ADR_TDIN): rd_mux = tdin_q;
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  assign mclk1_sel_o = mclk_q[1:0];
  assign mclk2_sel_o = mclk_q[5:4];
  assign sub1_sel_o  = sub_q[1:0];
  assign sub2_sel_o  = sub_q[5:4];
  assign cdin_sel_o  = cdin_q[1:0];
  assign tdin_sel_o  = tdin_q[5:4];
endmodule

// File: rtl/aud_mclk_route.sv
module aud_mclk_route (
  input  logic [1:0] sel1_i,
  input  logic [1:0] sel2_i,
  input  logic       osc1_i,
  input  logic       osc2_i,
  input  logic       hdr1_i,
  input  logic       hdr2_i,
  input  logic       rmck_i,
  output logic       mclk1_o,
  output logic       mclk2_o,
  output logic       hdr1_oe_o,
  output logic       hdr2_oe_o
);
  logic base1, base2, loop;

  always_comb begin
    unique case (sel1_i)
      2'd0:    base1 = osc1_i;
      2'd1:    base1 = hdr1_i;
      default: base1 = 1'b0;  // reserved, or copy resolved below
    endcase
    unique case (sel2_i)
      2'd0:    base2 = osc2_i;
      2'd1:    base2 = hdr2_i;
      2'd2:    base2 = rmck_i;
      default: base2 = 1'b0;
    endcase
  end

  assign loop    = (sel1_i == 2'd3) && (sel2_i == 2'd3);
  assign mclk1_o = loop ? osc1_i : (sel1_i == 2'd3) ? base2 : base1;
  assign mclk2_o = loop ? osc1_i : (sel2_i == 2'd3) ? base1 : base2;

  assign hdr1_oe_o = !(sel1_i == 2'd1 || sel1_i == 2'd2);
  assign hdr2_oe_o = (sel2_i != 2'd1);
endmodule

// File: rtl/aud_sub_sel.sv
module aud_sub_sel
  import aud_route_pkg::*;
(
  input  sub_mode_e        mode_i,
  input  logic [SUB_W-1:0] codec_i,
  input  logic [SUB_W-1:0] dev_i,
  input  logic [SUB_W-1:0] hdr_i,
  output logic [SUB_W-1:0] own_o,
  output logic             codec_ms_o,
  output logic             dev_ms_o,
  output logic             hdr_oe_o,
  output logic             copy_o
);
  always_comb begin
    unique case (mode_i)
      SUB_CODEC: own_o = codec_i;
      SUB_DEV:   own_o = dev_i;
      SUB_HDR:   own_o = hdr_i;
      default:   own_o = '0;
    endcase
  end

  assign codec_ms_o = (mode_i == SUB_CODEC);
  assign dev_ms_o   = (mode_i == SUB_DEV);
  assign hdr_oe_o   = (mode_i != SUB_HDR);
  assign copy_o     = (mode_i == SUB_COPY);
endmodule

// File: rtl/aud_data_sel.sv
module aud_data_sel
  import aud_route_pkg::*;
(
  input  din_sel_e sel_i,
  input  logic     rx_i,
  input  logic     loop_i,
  input  logic     hdr_i,
  output logic     data_o
);
  always_comb begin
    unique case (sel_i)
      DIN_RX:   data_o = rx_i;
      DIN_LOOP: data_o = loop_i;
      DIN_HDR:  data_o = hdr_i;
      default:  data_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/audio_route_matrix.sv
module audio_route_matrix
  import aud_route_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [REG_W-1:0] REV_ID = 8'h1A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              osc1_i,
  input  logic              osc2_i,
  input  logic              hdr1_mclk_i,
  input  logic              hdr2_mclk_i,
  input  logic              rx_rmck_i,
  output logic              mclk1_o,
  output logic              mclk2_o,
  output logic              hdr1_mclk_oe_o,
  output logic              hdr2_mclk_oe_o,
  input  logic [SUB_W-1:0]  codec_sub1_i,
  input  logic [SUB_W-1:0]  tx_sub_i,
  input  logic [SUB_W-1:0]  hdr1_sub_i,
  output logic [SUB_W-1:0]  codec_sub1_o,
  output logic [SUB_W-1:0]  tx_sub_o,
  output logic [SUB_W-1:0]  hdr1_sub_o,
  output logic              codec_ms1_o,
  output logic              tx_ms_o,
  output logic              hdr1_sub_oe_o,
  input  logic [SUB_W-1:0]  codec_sub2_i,
  input  logic [SUB_W-1:0]  rx_sub_i,
  input  logic [SUB_W-1:0]  hdr2_sub_i,
  output logic [SUB_W-1:0]  codec_sub2_o,
  output logic [SUB_W-1:0]  rx_sub_o,
  output logic [SUB_W-1:0]  hdr2_sub_o,
  output logic              codec_ms2_o,
  output logic              rx_ms_o,
  output logic              hdr2_sub_oe_o,
  input  logic              codec_sdout_i,
  input  logic              rx_sdout_i,
  input  logic              hdr_sdata_i,
  output logic              codec_sdin_o,
  output logic              tx_sdin_o
);
  logic [1:0] mclk1_sel, mclk2_sel, sub1_sel, sub2_sel, cdin_sel, tdin_sel;

  aud_route_regs #(.ADDR_W(ADDR_W), .REV_ID(REV_ID)) i_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .wr_en_i, .rd_en_i, .rdata_o,
    .mclk1_sel_o(mclk1_sel), .mclk2_sel_o(mclk2_sel),
    .sub1_sel_o(sub1_sel),   .sub2_sel_o(sub2_sel),
    .cdin_sel_o(cdin_sel),   .tdin_sel_o(tdin_sel)
  );

  aud_mclk_route i_mclk (
    .sel1_i(mclk1_sel), .sel2_i(mclk2_sel),
    .osc1_i, .osc2_i, .hdr1_i(hdr1_mclk_i), .hdr2_i(hdr2_mclk_i), .rmck_i(rx_rmck_i),
    .mclk1_o, .mclk2_o, .hdr1_oe_o(hdr1_mclk_oe_o), .hdr2_oe_o(hdr2_mclk_oe_o)
  );

  // Sub-clock domains: index 0 = domain 1, index 1 = domain 2
  logic      sub_loop;
  sub_mode_e mode    [NUM_DOM];
  logic [SUB_W-1:0] codec_src [NUM_DOM];
  logic [SUB_W-1:0] dev_src   [NUM_DOM];
  logic [SUB_W-1:0] hdr_src   [NUM_DOM];
  logic [SUB_W-1:0] own       [NUM_DOM];
  logic [SUB_W-1:0] bus       [NUM_DOM];
  logic [NUM_DOM-1:0] codec_ms, dev_ms, hdr_oe, copy;

  assign sub_loop     = (sub1_sel == 2'd3) && (sub2_sel == 2'd3);
  assign mode[0]      = sub_loop ? SUB_CODEC : sub_mode_e'(sub1_sel);
  assign mode[1]      = sub_mode_e'(sub2_sel);
  assign codec_src[0] = codec_sub1_i;
  assign codec_src[1] = codec_sub2_i;
  assign dev_src[0]   = tx_sub_i;
  assign dev_src[1]   = rx_sub_i;
  assign hdr_src[0]   = hdr1_sub_i;
  assign hdr_src[1]   = hdr2_sub_i;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    aud_sub_sel i_sub (
      .mode_i(mode[d]), .codec_i(codec_src[d]), .dev_i(dev_src[d]), .hdr_i(hdr_src[d]),
      .own_o(own[d]), .codec_ms_o(codec_ms[d]), .dev_ms_o(dev_ms[d]),
      .hdr_oe_o(hdr_oe[d]), .copy_o(copy[d])
    );
    // copy reads the other domain's own source; loop break keeps copy one-sided
    assign bus[d] = copy[d] ? own[NUM_DOM-1-d] : own[d];
  end

  assign codec_sub1_o  = bus[0];
  assign tx_sub_o      = bus[0];
  assign hdr1_sub_o    = bus[0];
  assign codec_ms1_o   = codec_ms[0];
  assign tx_ms_o       = dev_ms[0];
  assign hdr1_sub_oe_o = hdr_oe[0];
  assign codec_sub2_o  = bus[1];
  assign rx_sub_o      = bus[1];
  assign hdr2_sub_o    = bus[1];
  assign codec_ms2_o   = codec_ms[1];
  assign rx_ms_o       = dev_ms[1];
  assign hdr2_sub_oe_o = hdr_oe[1];

  din_sel_e din_sel [2];
  logic     din_out [2];
  assign din_sel[0] = din_sel_e'(cdin_sel);
  assign din_sel[1] = din_sel_e'(tdin_sel);

  for (genvar k = 0; k < 2; k++) begin : g_din
    aud_data_sel i_din (
      .sel_i(din_sel[k]), .rx_i(rx_sdout_i), .loop_i(codec_sdout_i),
      .hdr_i(hdr_sdata_i), .data_o(din_out[k])
    );
  end

  assign codec_sdin_o = din_out[0];
  assign tx_sdin_o    = din_out[1];
endmodule

// File: rtl/audio_route_matrix_chk.sv
module audio_route_matrix_chk #(
  parameter int ADDR_W = 8,
  parameter logic [7:0] REV_ID = 8'h1A
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_en_i,
  input logic [7:0]        rdata_o,
  input logic              osc1_i,
  input logic              mclk1_o,
  input logic              mclk2_o,
  input logic [1:0]        mclk1_sel,
  input logic [1:0]        mclk2_sel,
  input logic [1:0]        sub1_sel,
  input logic [1:0]        sub2_sel,
  input logic [1:0]        cdin_sel,
  input logic              codec_ms1_o,
  input logic              tx_ms_o,
  input logic              hdr1_sub_oe_o,
  input logic              codec_ms2_o,
  input logic              rx_ms_o,
  input logic              hdr2_sub_oe_o,
  input logic [1:0]        codec_sub1_i,
  input logic [1:0]        codec_sub2_o,
  input logic              codec_sdin_o
);
  logic cp1, cp2;
  assign cp1 = (sub1_sel == 2'd3) && (sub2_sel != 2'd3);
  assign cp2 = (sub2_sel == 2'd3);

  // R1
  rev_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == ADDR_W'(1) |=> rdata_o == REV_ID);
  // R4
  oob_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && (addr_i == '0 || addr_i > ADDR_W'(5)) |=> rdata_o == 8'h00);
  // R3
  rsv_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && (addr_i == ADDR_W'(2) || addr_i == ADDR_W'(3)) |=> (rdata_o & 8'hCC) == 8'h00);
  // R13
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
  // R7
  mclk_loop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclk1_sel == 2'd3 && mclk2_sel == 2'd3 |-> mclk1_o == osc1_i && mclk2_o == osc1_i);
  // R10
  sub_loop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub1_sel == 2'd3 && sub2_sel == 2'd3 |-> codec_ms1_o && codec_sub2_o == codec_sub1_i);
  // R11
  drv1_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({codec_ms1_o, tx_ms_o, !hdr1_sub_oe_o, cp1}));
  // R11
  drv2_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({codec_ms2_o, rx_ms_o, !hdr2_sub_oe_o, cp2}));
  // R12
  din_rsv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cdin_sel == 2'd3 |-> !codec_sdin_o);
endmodule

bind audio_route_matrix audio_route_matrix_chk #(.ADDR_W(ADDR_W), .REV_ID(REV_ID)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rd_en_i(rd_en_i), .rdata_o(rdata_o),
  .osc1_i(osc1_i), .mclk1_o(mclk1_o), .mclk2_o(mclk2_o),
  .mclk1_sel(mclk1_sel), .mclk2_sel(mclk2_sel), .sub1_sel(sub1_sel), .sub2_sel(sub2_sel),
  .cdin_sel(cdin_sel), .codec_ms1_o(codec_ms1_o), .tx_ms_o(tx_ms_o),
  .hdr1_sub_oe_o(hdr1_sub_oe_o), .codec_ms2_o(codec_ms2_o), .rx_ms_o(rx_ms_o),
  .hdr2_sub_oe_o(hdr2_sub_oe_o), .codec_sub1_i(codec_sub1_i), .codec_sub2_o(codec_sub2_o),
  .codec_sdin_o(codec_sdin_o)
);

// File: tb/test_audio_route_matrix.sv
module test_audio_route_matrix;
  localparam logic [7:0] REV = 8'h1A;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] addr = '0, wdata = '0, rdata;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic osc1, osc2, hdr1_m, hdr2_m, rmck;
  logic [1:0] c_sub1, t_sub, h_sub1, c_sub2, r_sub, h_sub2;
  logic c_sdo, r_sdo, h_sd;
  logic mclk1, mclk2, h1m_oe, h2m_oe, c_ms1, t_ms, h1_oe, c_ms2, r_ms, h2_oe, c_sdin, t_sdin;
  logic [1:0] c_sub1_o, t_sub_o, h_sub1_o, c_sub2_o, r_sub_o, h_sub2_o;

  audio_route_matrix #(.ADDR_W(8), .REV_ID(REV)) i_audio_route_matrix (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .rdata_o(rdata),
    .osc1_i(osc1), .osc2_i(osc2), .hdr1_mclk_i(hdr1_m), .hdr2_mclk_i(hdr2_m), .rx_rmck_i(rmck),
    .mclk1_o(mclk1), .mclk2_o(mclk2), .hdr1_mclk_oe_o(h1m_oe), .hdr2_mclk_oe_o(h2m_oe),
    .codec_sub1_i(c_sub1), .tx_sub_i(t_sub), .hdr1_sub_i(h_sub1),
    .codec_sub1_o(c_sub1_o), .tx_sub_o(t_sub_o), .hdr1_sub_o(h_sub1_o),
    .codec_ms1_o(c_ms1), .tx_ms_o(t_ms), .hdr1_sub_oe_o(h1_oe),
    .codec_sub2_i(c_sub2), .rx_sub_i(r_sub), .hdr2_sub_i(h_sub2),
    .codec_sub2_o(c_sub2_o), .rx_sub_o(r_sub_o), .hdr2_sub_o(h_sub2_o),
    .codec_ms2_o(c_ms2), .rx_ms_o(r_ms), .hdr2_sub_oe_o(h2_oe),
    .codec_sdout_i(c_sdo), .rx_sdout_i(r_sdo), .hdr_sdata_i(h_sd),
    .codec_sdin_o(c_sdin), .tx_sdin_o(t_sdin)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic drive(input logic [19:0] p);
    {osc1, osc2, hdr1_m, hdr2_m, rmck, c_sub1, c_sub2, t_sub, r_sub, h_sub1, h_sub2,
     c_sdo, r_sdo, h_sd} = p;
    #1;
  endtask

  // expected models from the requirement text
  function automatic logic [3:0] m_mclk(input logic [7:0] r2);
    logic [1:0] a, b; logic l1, l2, o1, o2;
    a = r2[1:0]; b = r2[5:4];
    l1 = (a == 0) ? osc1 : (a == 1) ? hdr1_m : 1'b0;
    l2 = (b == 0) ? osc2 : (b == 1) ? hdr2_m : (b == 2) ? rmck : 1'b0;
    if (a == 3 && b == 3) begin o1 = osc1; o2 = osc1; end
    else begin o1 = (a == 3) ? l2 : l1; o2 = (b == 3) ? l1 : l2; end
    return {o1, o2, !(a == 1 || a == 2), b != 1};
  endfunction

  function automatic logic [17:0] m_sub(input logic [7:0] r3);
    logic [1:0] a, b, l1, l2, bus1, bus2;
    a = r3[1:0]; b = r3[5:4];
    if (a == 3 && b == 3) a = 0;
    l1 = (a == 0) ? c_sub1 : (a == 1) ? t_sub : (a == 2) ? h_sub1 : 2'b00;
    l2 = (b == 0) ? c_sub2 : (b == 1) ? r_sub : (b == 2) ? h_sub2 : 2'b00;
    bus1 = (a == 3) ? l2 : l1;
    bus2 = (b == 3) ? l1 : l2;
    return {bus1, bus1, bus1, bus2, bus2, bus2,
            a == 0, a == 1, a != 2, b == 0, b == 1, b != 2};
  endfunction

  function automatic logic m_din(input logic [1:0] s);
    return (s == 0) ? r_sdo : (s == 1) ? c_sdo : (s == 2) ? h_sd : 1'b0;
  endfunction

  function automatic logic [17:0] a_sub();
    return {c_sub1_o, t_sub_o, h_sub1_o, c_sub2_o, r_sub_o, h_sub2_o,
            c_ms1, t_ms, h1_oe, c_ms2, r_ms, h2_oe};
  endfunction

  // {reg 0x02, reg 0x03, reg 0x04, reg 0x05}
  localparam int NV = 12;
  localparam logic [31:0] VEC [NV] = '{
    32'h00000000, 32'h11110110, 32'h22220220, 32'h33330330,
    32'h03030010, 32'h30300120, 32'h13230200, 32'h31320030,
    32'h21120310, 32'h32310100, 32'h23130230, 32'h12210020
  };
  localparam int NP = 3;
  localparam logic [19:0] PAT [NP] = '{20'h96E4B, 20'h691B4, 20'hC3A5D};

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, keep;
    drive(PAT[0]);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    drive(PAT[1]);
    // R2 reset routing: mclk2 = receiver clock, both domains device master
    chk("R2 mclk reset", {28'h0, mclk1, mclk2, h1m_oe, h2m_oe}, {28'h0, osc1, rmck, 2'b11});
    chk("R2 sub reset", {14'h0, a_sub()}, {14'h0, m_sub(8'h11)});
    rd(8'h02, d); chk("R2 0x02", d, 8'h20);
    rd(8'h03, d); chk("R2 0x03", d, 8'h11);
    rd(8'h04, d); chk("R2 0x04", d, 8'h00);
    rd(8'h05, d); chk("R2 0x05", d, 8'h00);
    rd(8'h01, d); chk("R1 rev", d, REV);
    wr(8'h01, 8'h00);
    rd(8'h01, d); chk("R1 rev write ignored", d, REV);

    foreach (VEC[i]) begin
      wr(8'h02, VEC[i][31:24]); wr(8'h03, VEC[i][23:16]);
      wr(8'h04, VEC[i][15:8]);  wr(8'h05, VEC[i][7:0]);
      for (int p = 0; p < NP; p++) begin
        drive(PAT[p]);
        chk("R5 R6 R7 mclk", {28'h0, mclk1, mclk2, h1m_oe, h2m_oe}, {28'h0, m_mclk(VEC[i][31:24])});
        chk("R8 R9 R10 sub", {14'h0, a_sub()}, {14'h0, m_sub(VEC[i][23:16])});
        chk("R12 data", {30'h0, c_sdin, t_sdin},
            {30'h0, m_din(VEC[i][9:8]), m_din(VEC[i][5:4])});
        @(negedge clk);
      end
    end

    // R11 every sub-clock mode pair, roles and buses
    for (int s = 0; s < 16; s++) begin
      wr(8'h03, {2'b00, s[3:2], 2'b00, s[1:0]});
      for (int p = 0; p < 2; p++) begin
        drive(PAT[p]);
        chk("R11 single driver", {14'h0, a_sub()},
            {14'h0, m_sub({2'b00, s[3:2], 2'b00, s[1:0]})});
      end
    end

    // R7 loop with each source pattern
    wr(8'h02, 8'h33);
    for (int p = 0; p < NP; p++) begin
      drive(PAT[p]);
      chk("R7 loop mclk1", {31'h0, mclk1}, {31'h0, osc1});
      chk("R7 loop mclk2", {31'h0, mclk2}, {31'h0, osc1});
    end
    // R6 reserved code: output low, header pin not driven
    wr(8'h02, 8'h02);
    drive(20'hFFFFF);
    chk("R6 reserved mclk1", {30'h0, mclk1, h1m_oe}, 32'h0);
    // R10 sub loop
    wr(8'h03, 8'h33);
    drive(PAT[2]);
    chk("R10 sub loop", {28'h0, c_sub2_o, c_ms1, t_ms}, {28'h0, c_sub1, 2'b10});

    // R3 reserved bits
    wr(8'h02, 8'hFF); rd(8'h02, d); chk("R3 0x02 mask", d, 8'h33);
    wr(8'h03, 8'hFF); rd(8'h03, d); chk("R3 0x03 mask", d, 8'h33);
    wr(8'h04, 8'hFF); rd(8'h04, d); chk("R3 0x04 mask", d, 8'h03);
    wr(8'h05, 8'hFF); rd(8'h05, d); chk("R3 0x05 mask", d, 8'h30);

    // R4 out of range
    wr(8'h02, 8'h12);
    rd(8'h02, keep);
    wr(8'h06, 8'hFF); wr(8'h00, 8'hFF); wr(8'h82, 8'hFF);
    rd(8'h06, d); chk("R4 read 0x06", d, 8'h00);
    rd(8'h00, d); chk("R4 read 0x00", d, 8'h00);
    rd(8'hFF, d); chk("R4 read 0xFF", d, 8'h00);
    rd(8'h02, d); chk("R4 write ignored", d, keep);

    // R13 hold without strobe
    rd(8'h01, d);
    @(negedge clk); addr = 8'h02;
    @(negedge clk); @(negedge clk);
    chk("R13 rdata hold", rdata, REV);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule